// File: doc/BRIEF.md
# Comparator Timer Channel

This block is a single compare channel for a system event timer. It watches a free-running 64-bit main counter that lives elsewhere and pulses an event output when the counter reaches a programmed comparator value. It can work in one-shot mode or in periodic mode. In periodic mode the comparator steps forward by a programmed period after each expiry, so the events repeat without software writing the comparator again.

Software programs the channel through a 32-bit write port. The port reaches one configuration word and the two halves of the comparator. A set-value bit chooses whether a comparator write in periodic mode loads the comparator itself or the period. A 32-bit mode reduces the channel to the low half of the counter. In that mode, one-shot operation also gives an event each time the low half of the counter is about to wrap.

A `run_i` input stands for the global counter enable. The registered outputs show the configuration word, comparator and period so that a bus decoder elsewhere can read them back.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset, the configuration word reads 0x30, with only the periodic-capable bit 4 and the 64-bit-capable bit 5 set. The comparator is all ones, the period is zero, and no event is raised.
- R2: A configuration write (select 0) stores only these bits: 1 (interrupt type), 2 (channel enable), 3 (periodic), 6 (set-value) and 8 (32-bit mode). Bits 4 and 5 always read 1, and every other bit reads 0.
- R3: A low comparator write (select 1) loads comparator bits 31:0 when the channel is one-shot or set-value is 1. When the channel is periodic, the same write also loads period bits 31:0, with bit 31 forced to 0 in 32-bit mode.
- R4: A high comparator write (select 2) loads comparator bits 63:32 when the channel is one-shot or set-value is 1. Otherwise it loads period bits 63:32, with bit 63 forced to 0. Period bit 63 is never 1.
- R5: The set-value bit returns to 0 after any comparator write of either half.
- R6: A configuration write with bit 8 set clears comparator bits 63:32 and period bits 63:31. While 32-bit mode is on, comparator bits 63:32 and period bits 63:32 stay 0, whatever is written to them.
- R7: The counter has reached the comparator when comparator minus counter is zero or negative as a signed number. This uses 32-bit arithmetic on the low halves in 32-bit mode and 64-bit arithmetic otherwise. The first cycle that reaches the comparator raises `evt_o` in the next cycle, and only one event is raised until the channel is armed again.
- R8: In periodic mode with a nonzero period, the comparator advances by the period on each clock while the counter has reached it. This gives one event per catch-up.
- R9: An event is raised only when `run_i` and the channel enable bit are both 1. A match seen while `run_i` is 1 but the enable bit is 0 is consumed without an event.
- R10: In 32-bit one-shot mode with the channel enabled, `evt_o` and `evt_wrap_o` both pulse one cycle after the low counter half first becomes all ones. No wrap event is raised in periodic or 64-bit mode.
- R11: Any comparator write arms the channel. If the counter has already reached the new comparator value, the event is raised two cycles after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Main counter value |
| run_i | input | 1 | Global counter and event enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 configuration, 1 comparator low, 2 comparator high |
| wr_data_i | input | 32 | Write data |
| cfg_o | output | 32 | Configuration word |
| cmp_o | output | 64 | Comparator value |
| period_o | output | 64 | Period value |
| evt_o | output | 1 | One-cycle expiry event |
| evt_wrap_o | output | 1 | Marks an event caused by a low-half counter wrap |

## Verification
Most wrong internal states show up one cycle later on `cmp_o`, `period_o` or `cfg_o`. Examples are a mis-steered comparator write, a set-value bit that does not clear, or a period MSB that is not masked. A wrong arming flag or a wrong choice of compare width shows only as a missing, extra or late `evt_o` pulse. That pulse appears in the cycle after the counter value that should cause it, so the event scoreboard ties every pulse to one exact cycle. Catch-up in periodic mode is seen as the final comparator value after a counter jump, together with exactly one event.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  // Write target selection
  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_CMP_LO = 2'd1,
    SEL_CMP_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Bit positions inside the configuration word
  localparam int unsigned BIT_LEVEL  = 1;
  localparam int unsigned BIT_EN     = 2;
  localparam int unsigned BIT_PER    = 3;
  localparam int unsigned BIT_PCAP   = 4;
  localparam int unsigned BIT_WCAP   = 5;
  localparam int unsigned BIT_SETV   = 6;
  localparam int unsigned BIT_M32    = 8;

  // Writable control flags held by the channel
  typedef struct packed {
    logic level;
    logic en;
    logic periodic;
    logic setval;
    logic mode32;
  } chan_flags_t;

endpackage

// File: rtl/ctc_regs.sv
module ctc_regs
  import ctc_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter bit          PER_CAP  = 1'b1,
  parameter bit          WIDE_CAP = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_sel_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic                  adv_i,
  output chan_flags_t           flags_o,
  output logic [WORD_W-1:0]     cfg_word_o,
  output logic [2*WORD_W-1:0]   cmp_o,
  output logic [2*WORD_W-1:0]   period_o,
  output logic                  cmp_wr_o
);

  localparam int unsigned CNT_W = 2 * WORD_W;

  chan_flags_t        flags_q;
  logic [CNT_W-1:0]   cmp_q;
  logic [CNT_W-1:0]   per_q;

  // Arithmetic helpers
  function automatic chan_flags_t cfg_decode(input logic [WORD_W-1:0] d);
    chan_flags_t f;
    f.level    = d[BIT_LEVEL];
    f.en       = d[BIT_EN];
    f.periodic = d[BIT_PER];
    f.setval   = d[BIT_SETV];
    f.mode32   = d[BIT_M32];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] lo_period(input logic [WORD_W-1:0] d,
                                                  input logic m32);
    return m32 ? {1'b0, d[WORD_W-2:0]} : d;
  endfunction

  function automatic logic [WORD_W-1:0] hi_period(input logic [WORD_W-1:0] d,
                                                  input logic m32);
    return m32 ? '0 : {1'b0, d[WORD_W-2:0]};
  endfunction

  function automatic logic [CNT_W-1:0] step_cmp(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] p,
                                                input logic m32);
    logic [WORD_W-1:0] lo_sum;
    lo_sum = c[WORD_W-1:0] + p[WORD_W-1:0];
    return m32 ? {{WORD_W{1'b0}}, lo_sum} : c + p;
  endfunction

  logic wr_cfg, wr_lo, wr_hi, load_cmp;
  assign wr_cfg   = wr_en_i && (wr_sel_i == SEL_CFG);
  assign wr_lo    = wr_en_i && (wr_sel_i == SEL_CMP_LO);
  assign wr_hi    = wr_en_i && (wr_sel_i == SEL_CMP_HI);
  assign load_cmp = !flags_q.periodic || flags_q.setval;
  assign cmp_wr_o = wr_lo || wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cmp_q   <= '1;
      per_q   <= '0;
    end else if (wr_cfg) begin
      flags_q <= cfg_decode(wr_data_i);
      if (wr_data_i[BIT_M32]) begin
        cmp_q <= {{WORD_W{1'b0}}, cmp_q[WORD_W-1:0]};
        per_q <= {{(WORD_W+1){1'b0}}, per_q[WORD_W-2:0]};
      end
    end else if (wr_lo) begin
      if (load_cmp) begin
        cmp_q[WORD_W-1:0] <= wr_data_i;
        if (flags_q.mode32) cmp_q[CNT_W-1:WORD_W] <= '0;
      end
      if (flags_q.periodic)
        per_q[WORD_W-1:0] <= lo_period(wr_data_i, flags_q.mode32);
      flags_q.setval <= 1'b0;
    end else if (wr_hi) begin
      if (load_cmp)
        cmp_q[CNT_W-1:WORD_W] <= flags_q.mode32 ? '0 : wr_data_i;
      else
        per_q[CNT_W-1:WORD_W] <= hi_period(wr_data_i, flags_q.mode32);
      flags_q.setval <= 1'b0;
    end else if (adv_i) begin
      cmp_q <= step_cmp(cmp_q, per_q, flags_q.mode32);
    end
  end

  always_comb begin
    cfg_word_o            = '0;
    cfg_word_o[BIT_LEVEL] = flags_q.level;
    cfg_word_o[BIT_EN]    = flags_q.en;
    cfg_word_o[BIT_PER]   = flags_q.periodic;
    cfg_word_o[BIT_PCAP]  = PER_CAP;
    cfg_word_o[BIT_WCAP]  = WIDE_CAP;
    cfg_word_o[BIT_SETV]  = flags_q.setval;
    cfg_word_o[BIT_M32]   = flags_q.mode32;
  end

  assign flags_o  = flags_q;
  assign cmp_o    = cmp_q;
  assign period_o = per_q;

  assert_period_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_q[CNT_W-1] == 1'b0);

  assert_period_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.mode32 |-> per_q[CNT_W-1:WORD_W-1] == '0);

  assert_cmp_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.mode32 |-> cmp_q[CNT_W-1:WORD_W] == '0);

  assert_setval_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_o |=> !flags_q.setval);

  assert_advance_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_en_i && !flags_q.mode32) |=> cmp_q == $past(cmp_q + per_q));

endmodule

// File: rtl/ctc_match.sv
module ctc_match
  import ctc_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*WORD_W-1:0]   count_i,
  input  logic [2*WORD_W-1:0]   cmp_i,
  input  logic [2*WORD_W-1:0]   period_i,
  input  chan_flags_t           flags_i,
  input  logic                  run_i,
  input  logic                  cmp_wr_i,
  output logic                  reached_o,
  output logic                  adv_o,
  output logic                  match_o
);

  localparam int unsigned CNT_W = 2 * WORD_W;

  // Signed difference test at the selected width
  function automatic logic has_reached(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] n,
                                       input logic m32);
    logic [CNT_W-1:0]  dw;
    logic [WORD_W-1:0] dn;
    dw = c - n;
    dn = c[WORD_W-1:0] - n[WORD_W-1:0];
    if (m32) return dn[WORD_W-1] || (dn == '0);
    else     return dw[CNT_W-1] || (dw == '0);
  endfunction

  logic armed_q, match_q, fire_now;

  assign reached_o = has_reached(cmp_i, count_i, flags_i.mode32);
  assign adv_o     = run_i && flags_i.periodic && (|period_i) && reached_o;
  assign fire_now  = run_i && armed_q && reached_o && !cmp_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (cmp_wr_i)       armed_q <= 1'b1;
      else if (fire_now)  armed_q <= 1'b0;
      else if (!reached_o) armed_q <= 1'b1;
      match_q <= fire_now && flags_i.en;
    end
  end

  assign match_o = match_q;

  assert_match_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> ($past(run_i) && $past(flags_i.en)));

  assert_match_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |=> !match_q);

  assert_match_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> $past(reached_o));

endmodule

// File: rtl/ctc_wrap.sv
module ctc_wrap
  import ctc_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] count_lo_i,
  input  chan_flags_t       flags_i,
  input  logic              run_i,
  output logic              wrap_o
);

  logic [WORD_W-1:0] prev_lo_q;
  logic              wrap_q, edge_hit;

  assign edge_hit = run_i && flags_i.en && flags_i.mode32 && !flags_i.periodic
                    && (&count_lo_i) && !(&prev_lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lo_q <= '1;
      wrap_q    <= 1'b0;
    end else begin
      prev_lo_q <= count_lo_i;
      wrap_q    <= edge_hit;
    end
  end

  assign wrap_o = wrap_q;

  assert_wrap_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> ($past(flags_i.mode32) && !$past(flags_i.periodic)));

  assert_wrap_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q);

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import ctc_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter bit          PER_CAP  = 1'b1,
  parameter bit          WIDE_CAP = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [63:0]         count_i,
  input  logic                run_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         cfg_o,
  output logic [63:0]         cmp_o,
  output logic [63:0]         period_o,
  output logic                evt_o,
  output logic                evt_wrap_o
);

  localparam int unsigned CNT_W = 2 * WORD_W;

  chan_flags_t        flags;
  logic [CNT_W-1:0]   cmp_val, per_val;
  logic               cmp_wr, reached, adv, match_evt, wrap_evt;

  ctc_regs #(.WORD_W(WORD_W), .PER_CAP(PER_CAP), .WIDE_CAP(WIDE_CAP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .adv_i      (adv),
    .flags_o    (flags),
    .cfg_word_o (cfg_o),
    .cmp_o      (cmp_val),
    .period_o   (per_val),
    .cmp_wr_o   (cmp_wr)
  );

  ctc_match #(.WORD_W(WORD_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_i   (count_i),
    .cmp_i     (cmp_val),
    .period_i  (per_val),
    .flags_i   (flags),
    .run_i     (run_i),
    .cmp_wr_i  (cmp_wr),
    .reached_o (reached),
    .adv_o     (adv),
    .match_o   (match_evt)
  );

  ctc_wrap #(.WORD_W(WORD_W)) u_wrap (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_lo_i (count_i[WORD_W-1:0]),
    .flags_i    (flags),
    .run_i      (run_i),
    .wrap_o     (wrap_evt)
  );

  assign cmp_o      = cmp_val;
  assign period_o   = per_val;
  assign evt_o      = match_evt || wrap_evt;
  assign evt_wrap_o = wrap_evt;

  assert_no_evt_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !evt_o);

  assert_rearm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !adv) |=> !match_evt || $past(run_i));

endmodule

// File: tb/cmp_timer_chan_test.sv
module cmp_timer_chan_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic        run_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd3;
  logic [31:0] wr_data_i = '0;
  logic [31:0] cfg_o;
  logic [63:0] cmp_o, period_o;
  logic        evt_o, evt_wrap_o;

  int unsigned nchk = 0;
  int unsigned nerr = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned cyc;
    bit          wrap;
    string       tag;
  } exp_evt_t;

  exp_evt_t evq[$];

  cmp_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .run_i(run_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .cfg_o(cfg_o), .cmp_o(cmp_o), .period_o(period_o),
    .evt_o(evt_o), .evt_wrap_o(evt_wrap_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every pulse must match the head of the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_o) begin
        if (evq.size() > 0 && evq[0].cyc == cyc) begin
          chk(evq[0].tag, {63'd0, evt_wrap_o}, {63'd0, evq[0].wrap});
          void'(evq.pop_front());
        end else begin
          nchk++; nerr++;
          $display("FAIL unexpected event at cycle %0d: actual 1 expected 0", cyc);
        end
      end else if (evq.size() > 0 && evq[0].cyc == cyc) begin
        nchk++; nerr++;
        $display("FAIL %s: missed event at cycle %0d, actual 0 expected 1", evq[0].tag, cyc);
        void'(evq.pop_front());
      end
    end
  end

  task automatic expect_evt(input int unsigned delay, input bit wrap, input string tag);
    exp_evt_t e;
    e.cyc = cyc + delay; e.wrap = wrap; e.tag = tag;
    evq.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_sel_i = 2'd3;
  endtask

  task automatic quiet(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (evt_o) bad++;
    end
    chk(tag, 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cfg", {32'd0, cfg_o}, 64'h30);
    chk("R1 cmp", cmp_o, '1);
    chk("R1 period", period_o, 64'd0);
    chk("R1 evt", {63'd0, evt_o}, 64'd0);

    // R2 writable mask, R6 truncation on mode set
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 cfg mask", {32'd0, cfg_o}, 64'h17E);
    chk("R6 cmp truncated", cmp_o, 64'h0000_0000_FFFF_FFFF);
    wr(2'd0, 32'h0);
    chk("R2 cfg cleared", {32'd0, cfg_o}, 64'h30);

    // R3 one-shot load, R7 single event per arming
    run_i = 1'b1; count_i = 64'd100;
    wr(2'd0, 32'h4);
    wr(2'd1, 32'd200);
    wr(2'd2, 32'd0);
    chk("R3 cmp low", cmp_o, 64'd200);
    chk("R3 period untouched", period_o, 64'd0);
    count_i = 64'd199; tick();
    count_i = 64'd200; expect_evt(1, 0, "R7 match at 200"); tick();
    count_i = 64'd201; tick();
    count_i = 64'd300;
    quiet(3, "R7 no repeat");

    // R9 gating by run and enable
    run_i = 1'b0;
    wr(2'd1, 32'd400);
    count_i = 64'd500;
    quiet(3, "R9 run low");
    run_i = 1'b1; expect_evt(1, 0, "R9 run high"); tick();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd600);
    count_i = 64'd700;
    quiet(3, "R9 enable low");
    wr(2'd0, 32'h4);
    quiet(3, "R9 swallowed");

    // R11 write of a comparator already passed
    count_i = 64'd1000;
    expect_evt(2, 0, "R11 past write");
    wr(2'd1, 32'd900);
    tick(); tick();

    // R7 compare width: 64-bit says ahead, 32-bit says passed
    count_i = 64'h20; tick();
    wr(2'd2, 32'd1);
    wr(2'd1, 32'h10);
    chk("R4 cmp high", cmp_o, 64'h0000_0001_0000_0010);
    quiet(3, "R7 64-bit ahead");
    expect_evt(2, 0, "R7 32-bit passed");
    wr(2'd0, 32'h104);
    chk("R6 cmp narrowed", cmp_o, 64'h10);
    tick(); tick();

    // R10 wrap event in 32-bit one-shot
    count_i = 64'hFFFF_FFF0;
    wr(2'd1, 32'h10);
    count_i = 64'hFFFF_FFFF; expect_evt(1, 1, "R10 wrap"); tick();
    count_i = 64'h1_0000_0005; tick();
    count_i = 64'h1_0000_0010; expect_evt(1, 0, "R10 match after wrap"); tick();
    tick();

    // R5 / R3 / R8 periodic 64-bit
    count_i = 64'd0; tick();
    wr(2'd0, 32'h4C);
    wr(2'd1, 32'd1000);
    chk("R5 setval cleared", {32'd0, cfg_o}, 64'h3C);
    chk("R3 cmp via setval", cmp_o, 64'd1000);
    chk("R3 period low", period_o, 64'd1000);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd100);
    chk("R3 periodic keeps cmp", cmp_o, 64'd1000);
    chk("R3 periodic period", period_o, 64'd100);
    count_i = 64'd999; tick();
    count_i = 64'd1000; expect_evt(1, 0, "R8 first"); tick();
    chk("R8 step", cmp_o, 64'd1100);
    count_i = 64'd1050; tick();
    count_i = 64'd1100; expect_evt(1, 0, "R8 second"); tick();
    count_i = 64'd1150; tick();
    count_i = 64'd1450; expect_evt(1, 0, "R8 catch-up"); tick(); tick(); tick();
    chk("R8 catch-up cmp", cmp_o, 64'd1500);
    quiet(2, "R8 single event");

    // R4 period high masking and setval high load
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R4 period MSB", period_o, 64'h7FFF_FFFF_0000_0064);
    chk("R4 cmp kept", cmp_o, 64'd1500);
    wr(2'd0, 32'h4C);
    wr(2'd2, 32'd5);
    chk("R4 cmp high setval", cmp_o, 64'h5_0000_05DC);

    // R6 narrowing in periodic 32-bit mode
    wr(2'd0, 32'h10C);
    chk("R6 cmp narrowed", cmp_o, 64'h5DC);
    chk("R6 period narrowed", period_o, 64'h64);
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R6 period bit31", period_o, 64'h7FFF_FFFF);
    chk("R6 cmp unchanged", cmp_o, 64'h5DC);
    wr(2'd2, 32'h1234);
    chk("R6 period high zero", period_o, 64'h7FFF_FFFF);
    count_i = 64'hFFFF_FFF0; tick();
    count_i = 64'hFFFF_FFFF;
    quiet(3, "R10 no wrap periodic");

    if (evq.size() != 0) begin
      nchk++; nerr++;
      $display("FAIL scoreboard: actual %0d pending expected 0", evq.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule